// File: doc/BRIEF.md
# Receive character queue with per-character status tagging

This block is the receive half of a classic byte-oriented serial port. It sits between the bit-level receiver and the register interface. Each character that arrives is first cut down to the configured word length. It is then queued together with four status flags of its own: parity error, framing error, break, and a summary error. A line-status vector is kept beside the queue. It shows whether data is waiting and whether an overrun happened. It also shows the error flags, but only those of the character that currently sits at the head of the queue.

The queue is DEPTH entries deep (16 by default) when `deep_mode` is 1. It holds a single character when `deep_mode` is 0. A received break is queued as a zero character tagged with break and error. A read strobe takes the head character off the queue and returns it combinationally in the same cycle. A separate status-read strobe clears the sticky error bits. The block also keeps a character-timeout counter. Every arriving character restarts that counter, and it counts up while data is waiting.

Top module: `uart_rx_fifo_tag`

## Requirements
- R1: Capacity is DEPTH entries when `deep_mode`=1 and 1 entry when `deep_mode`=0. Characters leave in arrival order, and storage positions wrap around. The mode may only be changed while the queue is empty.
- R2: Every arrival attempt (a character or a break, accepted or not) makes `tout_count` 0 after that clock edge. In any other cycle, the counter rises by one at each edge while data-ready is 1, stops at its all-ones value, and holds while the queue is empty.
- R3: An arrival while the queue already holds its capacity is discarded. After that edge `lsr[1]` (overrun) and `lsr[5]` (error) are 1, and data-ready stays 1.
- R4: The stored data keeps the low 5+`word_sel` bits of `rx_data`, so `word_sel` 0,1,2,3 keeps 5,6,7,8 bits. The bits above are stored as 0.
- R5: The flags of `rx_err` are bit0 parity, bit1 framing, bit2 break and bit3 error. They are shown in `lsr[2]`, `lsr[3]`, `lsr[4]` and `lsr[5]`, and only for the head entry. An arrival into an empty queue ORs its flags into `lsr` after that edge. An arrival behind other entries leaves `lsr` unchanged.
- R6: A `rx_break` strobe queues data 0 with the break and error flags set. It takes precedence over a `rx_valid` in the same cycle, and that character is not stored.
- R7: While `buf_rd` is 1 and the queue is not empty, `rd_data` shows the head data in that cycle, and the entry is removed at the edge. If entries remain, data-ready (`lsr[0]`) stays 1 and the new head's flags are ORed into `lsr`. If none remain, data-ready is 0 after the edge.
- R8: A `buf_rd` on an empty queue changes nothing. Data-ready stays 0, and the next character written is the next one read.
- R9: A `lsr_rd` strobe clears `lsr[5:1]` after that edge, unless a bit is set again in the same cycle. Data-ready is not affected.
- R10: After a synchronous active-low reset, `lsr` is 0, `tout_count` is 0, the queue is empty and the storage reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| deep_mode | input | 1 | 1: DEPTH-entry queue, 0: single entry |
| word_sel | input | 2 | Word length, 5 + value bits |
| rx_valid | input | 1 | One-cycle strobe for an arriving character |
| rx_data | input | 8 | Arriving character |
| rx_err | input | 4 | Flags of the arriving character: parity, framing, break, error |
| rx_break | input | 1 | One-cycle strobe that queues a break |
| buf_rd | input | 1 | Read strobe for the receive buffer (pop) |
| rd_data | output | 8 | Head character, valid in the cycle of `buf_rd` |
| lsr_rd | input | 1 | Status read strobe; clears the sticky bits |
| lsr | output | 6 | 0 ready, 1 overrun, 2 parity, 3 framing, 4 break, 5 error |
| tout_count | output | TOUT_W | Character timeout counter |

## Verification
`rd_data` is combinational, so the bench samples it one time unit after it raises `buf_rd`, before the clock edge that performs the pop. All `lsr` and `tout_count` effects of an arrival, pop or status read appear after exactly one edge. Every stimulus task therefore holds its strobe across one rising edge and compares against its arithmetic model at the following falling edge. The timeout checks count idle edges exactly: after a character and n idle edges the expected value is n, and the value stops at 255.

// File: rtl/uart_rx_fifo_pkg.sv
`timescale 1ns/1ps
// Shared types and bit positions for the receive queue.
// Assumes: a status vector of six bits, four flags per character.
package uart_rx_fifo_pkg;
    localparam int FLAG_W = 4;
    localparam int LSR_W  = 6;

    // Per-character flag positions (as driven on rx_err)
    localparam int F_PAR = 0;
    localparam int F_FRM = 1;
    localparam int F_BRK = 2;
    localparam int F_ERR = 3;

    // One queued character with its own status flags
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [7:0]        data;
    } rx_entry_t;
endpackage

// File: rtl/rx_char_former.sv
`timescale 1ns/1ps
// Builds the entry to be queued from an arriving character or a break.
// Assumes: rx_break wins over rx_valid in the same cycle.
module rx_char_former
    import uart_rx_fifo_pkg::*;
(
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic [FLAG_W-1:0] rx_err,
    input  logic              rx_break,
    input  logic [1:0]        word_sel,
    output logic              push_try,
    output rx_entry_t         push_entry
);
    logic [7:0] keep_mask;

    // Word-length mask: keeps 5 + word_sel low bits
    always_comb keep_mask = 8'hFF >> (2'd3 - word_sel);

    // Select between the break token and the masked character
    always_comb begin
        push_try = rx_valid | rx_break;
        if (rx_break) begin
            push_entry.data         = 8'h00;
            push_entry.flags        = '0;
            push_entry.flags[F_BRK] = 1'b1;
            push_entry.flags[F_ERR] = 1'b1;
        end else begin
            push_entry.data  = rx_data & keep_mask;
            push_entry.flags = rx_err;
        end
    end

    always_comb begin
        if (rx_break)
            assert_break_token_R6: assert (push_entry.data == 8'h00 && push_entry.flags[F_BRK]);
    end
endmodule

// File: rtl/rx_tag_store.sv
`timescale 1ns/1ps
// Circular store of tagged characters with read and write pointers.
// Assumes: deep_mode only changes while empty; DEPTH >= 2.
// Overflow is judged on the count before any same-cycle pop.
module rx_tag_store
    import uart_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deep_mode,
    input  logic              wr_try,
    input  rx_entry_t         wr_entry,
    input  logic              rd_req,
    output logic [7:0]        head_data,
    output logic [FLAG_W-1:0] next_flags,
    output logic [CW-1:0]     count,
    output logic              wr_accept,
    output logic              wr_overflow,
    output logic              rd_done
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;

    // Advance a pointer modulo the active capacity
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input logic deep);
        if (deep && p != LAST) return p + PW'(1);
        return '0;
    endfunction

    // Capacity and strobe qualification
    always_comb begin
        cap         = deep_mode ? CW'(DEPTH) : CW'(1);
        wr_accept   = wr_try & (count != cap);
        wr_overflow = wr_try & (count == cap);
        rd_done     = rd_req & (count != '0);
        head_data   = mem[rd_ptr].data;
        next_flags  = mem[bump(rd_ptr, deep_mode)].flags;
    end

    // Storage, pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_accept) begin
                mem[wr_ptr] <= wr_entry;
                wr_ptr      <= bump(wr_ptr, deep_mode);
            end
            if (rd_done) rd_ptr <= bump(rd_ptr, deep_mode);
            case ({wr_accept, rd_done})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);
    assert_ovf_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_overflow && !rd_done |=> $stable(count));
    assert_empty_pop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && count == '0 && !wr_try |=> count == '0 && $stable(rd_ptr));
endmodule

// File: rtl/rx_line_status.sv
`timescale 1ns/1ps
// Sticky line-status bits and the character timeout counter.
// Assumes: head flags are ORed in only when an entry becomes the head;
// a same-cycle set wins over a status-read clear.
module rx_line_status
    import uart_rx_fifo_pkg::*;
#(
    parameter int CW     = 5,
    parameter int TOUT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_try,
    input  logic              wr_accept,
    input  logic              wr_overflow,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic              rd_done,
    input  logic [CW-1:0]     count,
    input  logic [FLAG_W-1:0] next_flags,
    input  logic              lsr_rd,
    output logic [LSR_W-1:0]  lsr,
    output logic [TOUT_W-1:0] tout
);
    logic [FLAG_W-1:0] head_set;
    logic [4:0]        err_q, err_set;

    // Flags of the entry that becomes the head this cycle
    always_comb begin
        head_set = '0;
        if (wr_accept && count == '0) head_set = wr_flags;
        if (rd_done) begin
            if (count >= CW'(2))  head_set = next_flags;
            else if (wr_accept)   head_set = wr_flags;
        end
        err_set = {head_set[F_ERR] | wr_overflow, head_set[F_BRK],
                   head_set[F_FRM], head_set[F_PAR], wr_overflow};
    end

    // Sticky error bits: clear on status read, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (lsr_rd ? 5'b0 : err_q) | err_set;
    end

    // Timeout counter: restart on arrival, count while data waits
    always_ff @(posedge clk) begin
        if (!rst_n)                              tout <= '0;
        else if (wr_try)                         tout <= '0;
        else if (count != '0 && tout != '1)      tout <= tout + TOUT_W'(1);
    end

    // Status vector assembly
    always_comb lsr = {err_q, count != '0};

    assert_tout_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_try |=> tout == '0);
    assert_ovr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_overflow |=> lsr[1] && lsr[5] && lsr[0]);
    assert_dr_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && count == CW'(1) && !wr_try |=> !lsr[0]);
    assert_lsr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd && !wr_try && !rd_done |=> lsr[5:1] == 5'b0);
endmodule

// File: rtl/uart_rx_fifo_tag.sv
`timescale 1ns/1ps
// Receive queue top: forms entries, stores them with per-character
// flags, and keeps the line-status vector and timeout counter.
// Assumes: single-cycle strobes; deep_mode changes only when empty.
module uart_rx_fifo_tag
    import uart_rx_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TOUT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deep_mode,
    input  logic [1:0]        word_sel,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic [3:0]        rx_err,
    input  logic              rx_break,
    input  logic              buf_rd,
    output logic [7:0]        rd_data,
    input  logic              lsr_rd,
    output logic [5:0]        lsr,
    output logic [TOUT_W-1:0] tout_count
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              push_try, wr_accept, wr_overflow, rd_done;
    rx_entry_t         push_entry;
    logic [FLAG_W-1:0] next_flags;
    logic [CW-1:0]     count;

    rx_char_former u_former (
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_err    (rx_err),
        .rx_break  (rx_break),
        .word_sel  (word_sel),
        .push_try  (push_try),
        .push_entry(push_entry)
    );

    rx_tag_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .deep_mode  (deep_mode),
        .wr_try     (push_try),
        .wr_entry   (push_entry),
        .rd_req     (buf_rd),
        .head_data  (rd_data),
        .next_flags (next_flags),
        .count      (count),
        .wr_accept  (wr_accept),
        .wr_overflow(wr_overflow),
        .rd_done    (rd_done)
    );

    rx_line_status #(.CW(CW), .TOUT_W(TOUT_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_try     (push_try),
        .wr_accept  (wr_accept),
        .wr_overflow(wr_overflow),
        .wr_flags   (push_entry.flags),
        .rd_done    (rd_done),
        .count      (count),
        .next_flags (next_flags),
        .lsr_rd     (lsr_rd),
        .lsr        (lsr),
        .tout       (tout_count)
    );
endmodule

// File: tb/uart_rx_fifo_tag_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_tag_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       deep_mode = 1'b1;
    logic [1:0] word_sel = 2'd3;
    logic       rx_valid = 1'b0, rx_break = 1'b0, buf_rd = 1'b0, lsr_rd = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [3:0] rx_err = 4'h0;
    logic [7:0] rd_data;
    logic [5:0] lsr;
    logic [7:0] tout_count;

    int checks = 0, fails = 0;
    int m_cnt = 0, q_h = 0, q_t = 0, cap = 16;
    logic [7:0] q_d [16];
    logic [3:0] q_f [16];
    logic [5:1] m_err = '0;

    uart_rx_fifo_tag uut (
        .clk(clk), .rst_n(rst_n), .deep_mode(deep_mode), .word_sel(word_sel),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err), .rx_break(rx_break),
        .buf_rd(buf_rd), .rd_data(rd_data), .lsr_rd(lsr_rd), .lsr(lsr),
        .tout_count(tout_count)
    );

    always #2.5 clk = ~clk;

    initial begin
        #1000000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    function automatic int exp_lsr();
        return int'({m_err, m_cnt != 0});
    endfunction

    task automatic push(input logic [7:0] d, input logic [3:0] e, input logic brk, input string tag);
        logic [7:0] ed;
        logic [3:0] ef;
        rx_valid = 1'b1; rx_data = d; rx_err = e; rx_break = brk;
        step();
        rx_valid = 1'b0; rx_break = 1'b0;
        ed = brk ? 8'h00 : (d & (8'hFF >> (3 - word_sel)));
        ef = brk ? 4'b1100 : e;
        if (m_cnt == cap) begin
            m_err[1] = 1'b1; m_err[5] = 1'b1;
        end else begin
            if (m_cnt == 0) m_err[5:2] = m_err[5:2] | ef;
            q_d[q_t] = ed; q_f[q_t] = ef;
            q_t = (q_t + 1) % cap;
            m_cnt++;
        end
        chk({tag, " lsr after push"}, int'(lsr), exp_lsr());
        chk({"R2 timeout after push ", tag}, int'(tout_count), 0);
    endtask

    task automatic pop(input string tag);
        buf_rd = 1'b1;
        #1;
        if (m_cnt > 0) chk({tag, " rd_data"}, int'(rd_data), int'(q_d[q_h]));
        step();
        buf_rd = 1'b0;
        if (m_cnt > 0) begin
            q_h = (q_h + 1) % cap;
            m_cnt--;
            if (m_cnt > 0) m_err[5:2] = m_err[5:2] | q_f[q_h];
        end
        chk({tag, " lsr after pop"}, int'(lsr), exp_lsr());
    endtask

    task automatic rdlsr(input string tag);
        lsr_rd = 1'b1;
        step();
        lsr_rd = 1'b0;
        m_err = '0;
        chk({tag, " lsr after status read"}, int'(lsr), exp_lsr());
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step(); step();
        rst_n = 1'b1;
        m_cnt = 0; q_h = 0; q_t = 0; m_err = '0;
        chk("R10 lsr after reset", int'(lsr), 0);
        chk("R10 timeout after reset", int'(tout_count), 0);
        chk("R10 storage after reset", int'(rd_data), 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R4: every data value at every word length
        for (int s = 0; s < 4; s++) begin
            word_sel = 2'(s);
            for (int d = 0; d < 256; d++) begin
                push(8'(d), 4'h0, 1'b0, "R4");
                pop("R4");
            end
        end
        word_sel = 2'd3;

        // R1: partial use then full fill with wrap, R3 overflow
        for (int i = 0; i < 10; i++) push(8'(i + 100), 4'h0, 1'b0, "R1");
        for (int i = 0; i < 10; i++) pop("R1");
        for (int i = 0; i < 16; i++) push(8'(i * 13 + 1), 4'h0, 1'b0, "R1");
        push(8'hEE, 4'h0, 1'b0, "R3");
        for (int i = 0; i < 16; i++) pop("R1");
        chk("R1 empty after drain", int'(lsr[0]), 0);
        rdlsr("R9");

        // R1/R3: single-entry mode
        deep_mode = 1'b0; cap = 1; q_h = 0; q_t = 0;
        push(8'hA1, 4'h0, 1'b0, "R1");
        push(8'hB2, 4'h0, 1'b0, "R3");
        pop("R1");
        rdlsr("R9");
        push(8'hC3, 4'h0, 1'b0, "R1");
        pop("R1");
        deep_mode = 1'b1; cap = 16; q_h = 0; q_t = 0;

        // R5/R7/R9: flags shown only at the head
        push(8'h11, 4'b0001, 1'b0, "R5");
        rdlsr("R9");
        push(8'h22, 4'b0010, 1'b0, "R5");
        chk("R5 framing hidden behind head", int'(lsr[3]), 0);
        pop("R7");
        chk("R7 new head framing shown", int'(lsr[3]), 1);
        pop("R7");
        rdlsr("R9");
        for (int e = 0; e < 16; e++) begin
            push(8'(e), 4'(e), 1'b0, "R5");
            pop("R5");
            rdlsr("R9");
        end

        // R6: break wins over a same-cycle character
        rx_valid = 1'b1;
        push(8'h55, 4'h0, 1'b1, "R6");
        chk("R6 break flag", int'(lsr[4]), 1);
        pop("R6");
        rdlsr("R9");

        // R8: reads of an empty queue
        pop("R8");
        pop("R8");
        chk("R8 ready stays low", int'(lsr[0]), 0);
        push(8'h3C, 4'h0, 1'b0, "R8");
        pop("R8");

        // R2: timeout counting, restart and saturation
        push(8'h01, 4'h0, 1'b0, "R2");
        repeat (5) step();
        chk("R2 count after 5 idle", int'(tout_count), 5);
        push(8'h02, 4'h0, 1'b0, "R2");
        repeat (300) step();
        chk("R2 saturated", int'(tout_count), 255);
        pop("R2");
        pop("R2");
        repeat (3) step();
        chk("R2 holds when empty", int'(tout_count), 255);

        // R10: reset with content
        push(8'h77, 4'b1000, 1'b0, "R10");
        push(8'h88, 4'h0, 1'b0, "R10");
        do_reset();
        pop("R10");
        chk("R10 queue empty", int'(lsr[0]), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule